// File: doc/BRIEF.md
# Interrupt Enable and Halt Controller

This block sits beside the instruction decoder of a small 8-bit core. It holds the global interrupt-enable bit, the halted state and a sticky trap for undefined opcodes. On every clock, which is one tick of the core, it tells the core whether an instruction may be fetched and executed. When the decoder presents an opcode that this block owns, the block reports that instruction's cycle count. It also supplies the constant register values that the core loads when execution starts.

The core offers a decoded opcode with a valid strobe. The block acts on the opcode only when `issue` is high. A pending-interrupt line from the interrupt logic wakes a halted core. Vector dispatch, the stack memory and the per-source flag and mask registers live elsewhere. On a return-from-interrupt the block raises `ret_pop` for one tick, which asks the core to pop the return address.

Top module: `irq_halt_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `ime`, `halted` and `trap` are 0 and `issue` is 1.
- R2: The reset-value outputs are PC=0x0100, SP=0xFFFE, AF=0x01B0, BC=0x0013, DE=0x00D8 and HL=0x014D.
- R3: An executed opcode 0xF3 reports 4 cycles in its tick, and `ime` is 0 from the next tick on.
- R4: An executed opcode 0xFB reports 4 cycles in its tick, and `ime` is 1 from the next tick on.
- R5: An executed opcode 0xD9 raises `ret_pop` and reports 4 cycles in its tick, and `ime` is 1 from the next tick on. `ret_pop` is 0 for every other opcode.
- R6: An executed opcode 0x76 reports 1 cycle, and `halted` is 1 from the next tick on. While halted, `issue` is 0, each tick reports 1 cycle, and offered opcodes change no state.
- R7: A halted core leaves the halted state on the tick after the first tick with `irq_pending` high. This happens whatever the value of `ime`. While the core is not halted, `irq_pending` has no effect and does not cancel a 0x76 that executes in the same tick.
- R8: An executed opcode 0x10 reports 1 cycle and changes neither `ime` nor `halted`.
- R9: Executing any of 0xD3, 0xDB, 0xDD, 0xE3, 0xE4, 0xEB, 0xEC, 0xED, 0xF4, 0xFC or 0xFD sets `trap` from the next tick on. No other opcode sets it. `trap` holds until reset. While it is set, `issue` is 0, 0 cycles are reported and offered opcodes change no state.
- R10: Any other opcode reports 0 cycles and changes no state. An opcode offered with `op_valid` low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one core tick per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | A decoded opcode is offered this tick |
| op_code | input | 8 | Opcode byte |
| irq_pending | input | 1 | An enabled interrupt source is pending |
| issue | output | 1 | Core may fetch and execute this tick |
| ret_pop | output | 1 | Return-from-interrupt executing: pop PC |
| tick_cycles | output | 3 | Cycles consumed this tick by owned opcodes or idling |
| ime | output | 1 | Global interrupt enable |
| halted | output | 1 | Core is halted |
| trap | output | 1 | Undefined opcode was executed |
| pc_init | output | 16 | Start program counter |
| sp_init | output | 16 | Start stack pointer |
| af_init | output | 16 | Start A and flag register pair |
| bc_init | output | 16 | Start B/C pair |
| de_init | output | 16 | Start D/E pair |
| hl_init | output | 16 | Start H/L pair |

## Verification
Several conditions are hard to reach from the ports. One is the wake-up from halt while `ime` is set. Another is a HALT that executes in the same tick as a pending interrupt. In both cases the state has to be built by a sequence of opcodes, and then the pending line has to be pulsed at a chosen tick. The trap is sticky, so it can be tested for one opcode only per reset. The bench therefore resets before each of the 256 opcode values, sets `ime` first, and after any trap offers 0xF3 to show that the trapped core ignores it.

// File: rtl/irqh_pkg.sv
// Shared types and opcode constants for the interrupt-enable / halt controller.
// Assumes an 8-bit opcode space.
package irqh_pkg;

    typedef enum logic [2:0] {
        CLS_OTHER,
        CLS_DI,
        CLS_EI,
        CLS_RETI,
        CLS_HALT,
        CLS_STOP,
        CLS_BAD
    } op_class_e;

    localparam int OPC_W = 8;

    localparam logic [OPC_W-1:0] OPC_DI   = 8'hF3;
    localparam logic [OPC_W-1:0] OPC_EI   = 8'hFB;
    localparam logic [OPC_W-1:0] OPC_RETI = 8'hD9;
    localparam logic [OPC_W-1:0] OPC_HALT = 8'h76;
    localparam logic [OPC_W-1:0] OPC_STOP = 8'h10;

    localparam int NUM_BAD = 11;
    localparam logic [OPC_W-1:0] BAD_OPS [NUM_BAD] = '{
        8'hFD, 8'hFC, 8'hF4, 8'hED, 8'hEC, 8'hEB,
        8'hE4, 8'hE3, 8'hDD, 8'hDB, 8'hD3
    };

endpackage

// File: rtl/irqh_decode.sv
// Classifies an opcode into the groups this controller acts on.
// Purely combinational; the undefined-opcode match is one comparator per list entry.
module irqh_decode
    import irqh_pkg::*;
(
    input  logic [OPC_W-1:0] op_code,
    output op_class_e        op_class
);

    logic [NUM_BAD-1:0] bad_hit;

    // One equality comparator per undefined opcode
    for (genvar i = 0; i < NUM_BAD; i++) begin : g_bad
        assign bad_hit[i] = (op_code == BAD_OPS[i]);
    end

    // Map the opcode onto its class
    always_comb begin
        if (|bad_hit)                  op_class = CLS_BAD;
        else if (op_code == OPC_DI)    op_class = CLS_DI;
        else if (op_code == OPC_EI)    op_class = CLS_EI;
        else if (op_code == OPC_RETI)  op_class = CLS_RETI;
        else if (op_code == OPC_HALT)  op_class = CLS_HALT;
        else if (op_code == OPC_STOP)  op_class = CLS_STOP;
        else                           op_class = CLS_OTHER;
    end

endmodule

// File: rtl/irqh_state.sv
// Holds the interrupt-enable bit, the halted state and the sticky trap.
// Assumes `exec` is only high on a tick in which the core is issuing.
module irqh_state
    import irqh_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      exec,
    input  op_class_e op_class,
    input  logic      irq_pending,
    output logic      ime,
    output logic      halted,
    output logic      trap
);

    // Interrupt-enable latch: set by EI / RETI, cleared by DI
    always_ff @(posedge clk) begin
        if (!rst_n)
            ime <= 1'b0;
        else if (exec && op_class == CLS_DI)
            ime <= 1'b0;
        else if (exec && (op_class == CLS_EI || op_class == CLS_RETI))
            ime <= 1'b1;
    end

    // Halt state: entered by HALT, left on any pending interrupt
    always_ff @(posedge clk) begin
        if (!rst_n)
            halted <= 1'b0;
        else if (halted && irq_pending)
            halted <= 1'b0;
        else if (exec && op_class == CLS_HALT)
            halted <= 1'b1;
    end

    // Trap: set by an undefined opcode, held until reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            trap <= 1'b0;
        else if (exec && op_class == CLS_BAD)
            trap <= 1'b1;
    end

    a_r3_di_clears: assert property (@(posedge clk) disable iff (!rst_n)
        exec && op_class == CLS_DI |=> !ime);
    a_r4_ei_sets: assert property (@(posedge clk) disable iff (!rst_n)
        exec && op_class == CLS_EI |=> ime);
    a_r5_reti_sets: assert property (@(posedge clk) disable iff (!rst_n)
        exec && op_class == CLS_RETI |=> ime);
    a_r6_halt_enters: assert property (@(posedge clk) disable iff (!rst_n)
        exec && op_class == CLS_HALT |=> halted);
    a_r7_wake: assert property (@(posedge clk) disable iff (!rst_n)
        halted && irq_pending |=> !halted);
    a_r8_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        exec && op_class == CLS_STOP |=> $stable(ime) && $stable(halted));
    a_r9_trap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        trap |=> trap);

endmodule

// File: rtl/irqh_reset_vals.sv
// Drives the constant register values the core loads when execution starts.
// All values are parameters; no state.
module irqh_reset_vals #(
    parameter int              RW      = 16,
    parameter logic [RW-1:0]   PC_VAL  = 16'h0100,
    parameter logic [RW-1:0]   SP_VAL  = 16'hFFFE,
    parameter logic [RW-1:0]   AF_VAL  = 16'h01B0,
    parameter logic [RW-1:0]   BC_VAL  = 16'h0013,
    parameter logic [RW-1:0]   DE_VAL  = 16'h00D8,
    parameter logic [RW-1:0]   HL_VAL  = 16'h014D
) (
    output logic [RW-1:0] pc_init,
    output logic [RW-1:0] sp_init,
    output logic [RW-1:0] af_init,
    output logic [RW-1:0] bc_init,
    output logic [RW-1:0] de_init,
    output logic [RW-1:0] hl_init
);

    // Tie each output to its parameter
    assign pc_init = PC_VAL;
    assign sp_init = SP_VAL;
    assign af_init = AF_VAL;
    assign bc_init = BC_VAL;
    assign de_init = DE_VAL;
    assign hl_init = HL_VAL;

endmodule

// File: rtl/irq_halt_ctrl.sv
// Interrupt-enable and halt controller top. It gates instruction issue,
// reports cycle counts for the opcodes it owns and idle ticks, and exports
// the start-up register values. One clock equals one core tick.
module irq_halt_ctrl
    import irqh_pkg::*;
#(
    parameter int CYC_W    = 3,
    parameter int CYC_LONG = 4,
    parameter int CYC_ONE  = 1,
    parameter int RW       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [OPC_W-1:0] op_code,
    input  logic             irq_pending,
    output logic             issue,
    output logic             ret_pop,
    output logic [CYC_W-1:0] tick_cycles,
    output logic             ime,
    output logic             halted,
    output logic             trap,
    output logic [RW-1:0]    pc_init,
    output logic [RW-1:0]    sp_init,
    output logic [RW-1:0]    af_init,
    output logic [RW-1:0]    bc_init,
    output logic [RW-1:0]    de_init,
    output logic [RW-1:0]    hl_init
);

    localparam logic [CYC_W-1:0] C_LONG = CYC_W'(CYC_LONG);
    localparam logic [CYC_W-1:0] C_ONE  = CYC_W'(CYC_ONE);

    op_class_e op_class;
    logic      exec;

    irqh_decode u_decode (
        .op_code  (op_code),
        .op_class (op_class)
    );

    irqh_state u_state (
        .clk         (clk),
        .rst_n       (rst_n),
        .exec        (exec),
        .op_class    (op_class),
        .irq_pending (irq_pending),
        .ime         (ime),
        .halted      (halted),
        .trap        (trap)
    );

    irqh_reset_vals #(.RW(RW)) u_rstv (
        .pc_init (pc_init),
        .sp_init (sp_init),
        .af_init (af_init),
        .bc_init (bc_init),
        .de_init (de_init),
        .hl_init (hl_init)
    );

    // Issue gate and executed-opcode strobe
    assign issue   = !halted && !trap;
    assign exec    = issue && op_valid;
    assign ret_pop = exec && (op_class == CLS_RETI);

    // Cycle count for this tick
    always_comb begin
        tick_cycles = '0;
        if (trap)
            tick_cycles = '0;
        else if (halted)
            tick_cycles = C_ONE;
        else if (op_valid) begin
            case (op_class)
                CLS_DI, CLS_EI, CLS_RETI: tick_cycles = C_LONG;
                CLS_HALT, CLS_STOP:       tick_cycles = C_ONE;
                default:                  tick_cycles = '0;
            endcase
        end
    end

    a_r9_trap_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trap) |-> !issue && !ret_pop);
    a_r6_halt_no_state: assert property (@(posedge clk) disable iff (!rst_n)
        halted && !irq_pending |=> $stable(ime) && halted && !trap);

endmodule

// File: tb/irq_halt_ctrl_tb.sv
// Directed bench for the interrupt-enable / halt controller.
module irq_halt_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [7:0]  op_code = 8'h00;
    logic        irq_pending = 1'b0;
    logic        issue, ret_pop, ime, halted, trap;
    logic [2:0]  tick_cycles;
    logic [15:0] pc_init, sp_init, af_init, bc_init, de_init, hl_init;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // values sampled before the edge of the last step
    logic       s_issue, s_pop;
    logic [2:0] s_cyc;

    always #5 clk = ~clk;

    irq_halt_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .irq_pending(irq_pending), .issue(issue), .ret_pop(ret_pop),
        .tick_cycles(tick_cycles), .ime(ime), .halted(halted), .trap(trap),
        .pc_init(pc_init), .sp_init(sp_init), .af_init(af_init),
        .bc_init(bc_init), .de_init(de_init), .hl_init(hl_init)
    );

    function automatic bit is_bad(input logic [7:0] op);
        return op == 8'hD3 || op == 8'hDB || op == 8'hDD || op == 8'hE3 ||
               op == 8'hE4 || op == 8'hEB || op == 8'hEC || op == 8'hED ||
               op == 8'hF4 || op == 8'hFC || op == 8'hFD;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; op_valid = 1'b0; irq_pending = 1'b0; op_code = 8'h00;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One tick: drive at negedge, sample combinational outputs, pass the edge
    task automatic step(input logic [7:0] op, input logic v, input logic irq);
        @(negedge clk);
        op_code = op; op_valid = v; irq_pending = irq;
        #1;
        s_issue = issue; s_pop = ret_pop; s_cyc = tick_cycles;
        @(posedge clk);
        #1;
        op_valid = 1'b0; irq_pending = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        chk("R1 ime", ime, 0);
        chk("R1 halted", halted, 0);
        chk("R1 trap", trap, 0);
        chk("R1 issue", issue, 1);
        chk("R2 pc", pc_init, 16'h0100);
        chk("R2 sp", sp_init, 16'hFFFE);
        chk("R2 af", af_init, 16'h01B0);
        chk("R2 bc", bc_init, 16'h0013);
        chk("R2 de", de_init, 16'h00D8);
        chk("R2 hl", hl_init, 16'h014D);
    endtask

    task automatic t_di_ei();
        do_reset();
        step(8'hFB, 1, 0);
        chk("R4 cycles", s_cyc, 4); chk("R4 ime", ime, 1);
        step(8'hFB, 1, 0);
        chk("R4 ime again", ime, 1);
        step(8'hF3, 1, 0);
        chk("R3 cycles", s_cyc, 4); chk("R3 ime", ime, 0);
        step(8'hF3, 1, 0);
        chk("R3 ime again", ime, 0);
    endtask

    task automatic t_reti();
        do_reset();
        step(8'hD9, 1, 0);
        chk("R5 pop", s_pop, 1); chk("R5 cycles", s_cyc, 4); chk("R5 ime", ime, 1);
        step(8'hFB, 1, 0);
        chk("R5 no pop", s_pop, 0);
    endtask

    task automatic t_stop();
        do_reset();
        step(8'hFB, 1, 0);
        step(8'h10, 1, 0);
        chk("R8 cycles", s_cyc, 1);
        chk("R8 ime", ime, 1); chk("R8 halted", halted, 0);
        chk("R8 issue", issue, 1);
    endtask

    task automatic t_halt_wake();
        do_reset();
        step(8'h76, 1, 0);
        chk("R6 cycles", s_cyc, 1); chk("R6 halted", halted, 1);
        step(8'hFB, 1, 0);
        chk("R6 issue", s_issue, 0); chk("R6 idle cycles", s_cyc, 1);
        chk("R6 ignored ime", ime, 0);
        step(8'h00, 0, 0);
        chk("R6 stays halted", halted, 1);
        step(8'h00, 0, 1);
        chk("R7 wake tick no issue", s_issue, 0);
        chk("R7 woke ime0", halted, 0);
        step(8'h00, 1, 0);
        chk("R7 issue after wake", s_issue, 1);
        step(8'hFB, 1, 0);
        step(8'h76, 1, 0);
        step(8'h00, 0, 1);
        chk("R7 woke ime1", halted, 0); chk("R7 ime kept", ime, 1);
        step(8'h00, 1, 1);
        chk("R7 irq while running", halted, 0);
        step(8'h76, 1, 1);
        chk("R7 halt with irq", halted, 1);
        step(8'h00, 0, 1);
        chk("R7 later wake", halted, 0);
    endtask

    task automatic t_other();
        do_reset();
        step(8'hFB, 1, 0);
        step(8'h3E, 1, 0);
        chk("R10 cycles", s_cyc, 0); chk("R10 ime", ime, 1);
        chk("R10 halted", halted, 0); chk("R10 trap", trap, 0);
        step(8'hF3, 0, 0);
        chk("R10 invalid strobe", ime, 1);
        step(8'hD3, 0, 0);
        chk("R10 bad not valid", trap, 0);
    endtask

    task automatic t_trap_all();
        for (int op = 0; op < 256; op++) begin
            do_reset();
            step(8'hFB, 1, 0);
            step(op[7:0], 1, 0);
            chk($sformatf("R9 trap op %02h", op), trap, is_bad(op[7:0]));
            if (is_bad(op[7:0])) begin
                step(8'hF3, 1, 1);
                chk("R9 no issue", s_issue, 0); chk("R9 cycles", s_cyc, 0);
                chk("R9 ignored ime", ime, 1); chk("R9 sticky", trap, 1);
            end
        end
    endtask

    initial begin
        t_reset();
        t_di_ei();
        t_reti();
        t_stop();
        t_halt_wake();
        t_other();
        t_trap_all();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule